// File: doc/BRIEF.md
# Multichannel Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a CPU and a serializer. The CPU pushes interleaved multichannel samples, one 24-bit sample per write, into a word RAM. The serializer drains one sample per pop request. The channel count can be set from 1 to 8. The RAM is shared across all channels. The usable frame capacity is the RAM depth divided by the channel count rounded up to a power of two. For example, three channels use the same frame count as four.

The CPU sees three registers, selected by a 2-bit address. Address 0 is control, address 1 is status and address 2 is sample data. The status word reports the stored level in whole frames. It also carries two sticky error flags: one for writes that were dropped because the FIFO was full, and one for pops made while it was empty. A level-type interrupt request tells software when the FIFO has drained to half its frame capacity or below. A self-clearing flush command empties the FIFO without touching the error flags.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the FIFO is empty, the status word reads 0, the control word reads 0 and `half_irq` is low.
- R2: A write to address 2 stores `cpu_wdata[23:0]` and ignores the upper bits. Samples leave in the order written. `pop_data` shows the popped sample from the cycle after `pop_req`.
- R3: The frame capacity is `DEPTH >> s`, where `s` is 0, 1, 2, 2, 3, 3, 3 or 3 for 1 to 8 channels. `DEPTH` is `256 << SIZE_CODE`. The FIFO accepts up to capacity × channels words.
- R4: A data write while the FIFO holds capacity × channels words is dropped and sets status bit 4. That flag stays set until it is cleared.
- R5: A pop while the FIFO is empty gives 0 on `pop_data` and sets status bit 0. That flag stays set until it is cleared.
- R6: Status bits [8 +: LVL_W] report the level in whole frames, which is the stored word count divided by the channel count and rounded down. LVL_W is 9 by default, giving bits [16:8].
- R7: A write to address 1 keeps each error flag only where the written bit (4 or 0) is 1. Writing 0 clears both flags.
- R8: Writing control bit 0 = 1 makes that bit read 1 for exactly one cycle. The FIFO is then empty, and both error flags are unchanged.
- R9: Control bit 20 enables the interrupt. `half_irq` is high exactly when bit 20 is set and the frame level is at most half the frame capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data of the selected register (combinational) |
| ch_minus1 | input | 3 | Channel count minus one |
| pop_req | input | 1 | Serializer request for one sample |
| pop_data | output | 24 | Sample returned for the previous request |
| half_irq | output | 1 | Half-level interrupt request (level) |

## Verification
A wrong occupancy count shows up at once in the status level field and in `half_irq`. It also surfaces when an overrun or underrun flag appears one write or one pop too early or too late. A wrong read or write pointer shows up on `pop_data` on the first pop after the fault, as a sample out of order. Wrong capacity arithmetic for a given channel count shows up as a level that stops below the expected frame capacity, or as a missing overrun flag, after one full fill.

// File: rtl/audio_tx_fifo_pkg.sv
package audio_tx_fifo_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_STATUS = 2'd1,
        REG_DATA   = 2'd2
    } reg_sel_e;

    localparam int SAMPLE_W    = 24;
    localparam int CTRL_FLUSH  = 0;
    localparam int CTRL_IRQ_EN = 20;
    localparam int STAT_UNDER  = 0;
    localparam int STAT_OVER   = 4;
    localparam int STAT_LEVEL  = 8;
endpackage

// File: rtl/audio_tx_fifo_ram.sv
module audio_tx_fifo_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/audio_tx_fifo_geom.sv
module audio_tx_fifo_geom #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [2:0]    ch_minus1,
    input  logic [CW-1:0] words,
    output logic [CW-1:0] cap_frames,
    output logic [CW-1:0] cap_words,
    output logic [CW-1:0] level
);
    logic [1:0]    shift;
    logic [CW-1:0] ch_w;

    assign ch_w = CW'({1'b0, ch_minus1}) + CW'(1);

    always_comb begin
        unique case (ch_minus1)
            3'd0:          shift = 2'd0;
            3'd1:          shift = 2'd1;
            3'd2, 3'd3:    shift = 2'd2;
            default:       shift = 2'd3;
        endcase
    end

    assign cap_frames = CW'(DEPTH) >> shift;
    assign cap_words  = cap_frames * ch_w;

    always_comb begin
        unique case (ch_minus1)
            3'd0:    level = words;
            3'd1:    level = words >> 1;
            3'd2:    level = words / CW'(3);
            3'd3:    level = words >> 2;
            3'd4:    level = words / CW'(5);
            3'd5:    level = words / CW'(6);
            3'd6:    level = words / CW'(7);
            default: level = words >> 3;
        endcase
    end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audio_tx_fifo_pkg::*;
#(
    parameter int SIZE_CODE = 0,
    localparam int DEPTH    = 256 << SIZE_CODE,
    localparam int AW       = $clog2(DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic [1:0]  cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    input  logic [2:0]  ch_minus1,
    input  logic        pop_req,
    output logic [23:0] pop_data,
    output logic        half_irq
);
    typedef struct packed {
        logic [AW-1:0]       wr_ptr;
        logic [AW-1:0]       rd_ptr;
        logic [CW-1:0]       count;
        logic                over;
        logic                under;
        logic                irq_en;
        logic                flush;
        logic [SAMPLE_W-1:0] pop_data;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0]       cap_frames, cap_words, level;
    logic [SAMPLE_W-1:0] ram_rdata;
    logic                push, pop_ok;
    logic                wr_data, wr_ctrl, wr_stat;
    logic                full, empty;

    audio_tx_fifo_geom #(.DEPTH(DEPTH)) u_geom (
        .ch_minus1 (ch_minus1),
        .words     (st_q.count),
        .cap_frames(cap_frames),
        .cap_words (cap_words),
        .level     (level)
    );

    audio_tx_fifo_ram #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_ram (
        .clk  (clk),
        .we   (push),
        .waddr(st_q.wr_ptr),
        .wdata(cpu_wdata[SAMPLE_W-1:0]),
        .raddr(st_q.rd_ptr),
        .rdata(ram_rdata)
    );

    assign wr_data = cpu_wr && (cpu_addr == REG_DATA);
    assign wr_ctrl = cpu_wr && (cpu_addr == REG_CTRL);
    assign wr_stat = cpu_wr && (cpu_addr == REG_STATUS);
    assign full    = st_q.count >= cap_words;
    assign empty   = st_q.count == '0;
    assign push    = wr_data && !full && !st_q.flush;
    assign pop_ok  = pop_req && !empty && !st_q.flush;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;

        if (wr_stat) begin
            st_d.over  = st_q.over  & cpu_wdata[STAT_OVER];
            st_d.under = st_q.under & cpu_wdata[STAT_UNDER];
        end

        if (st_q.flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (push) begin
                st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            end
            if (wr_data && full) begin
                st_d.over = 1'b1;
            end
            if (pop_ok) begin
                st_d.rd_ptr   = st_q.rd_ptr + AW'(1);
                st_d.pop_data = ram_rdata;
            end else if (pop_req) begin
                st_d.pop_data = '0;
                st_d.under    = 1'b1;
            end
            st_d.count = st_q.count + CW'(push) - CW'(pop_ok);
        end

        if (wr_ctrl) begin
            st_d.irq_en = cpu_wdata[CTRL_IRQ_EN];
            st_d.flush  = cpu_wdata[CTRL_FLUSH];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            REG_CTRL: begin
                cpu_rdata[CTRL_IRQ_EN] = st_q.irq_en;
                cpu_rdata[CTRL_FLUSH]  = st_q.flush;
            end
            REG_STATUS: begin
                cpu_rdata[STAT_LEVEL +: CW] = level;
                cpu_rdata[STAT_OVER]        = st_q.over;
                cpu_rdata[STAT_UNDER]       = st_q.under;
            end
            default: cpu_rdata = '0;
        endcase
    end

    assign pop_data = st_q.pop_data;
    assign half_irq = st_q.irq_en && (level <= (cap_frames >> 1));

    logic [CW-1:0] occ_words;
    logic          flag_over, flag_under, flush_pend, irq_enable;
    assign occ_words  = st_q.count;
    assign flag_over  = st_q.over;
    assign flag_under = st_q.under;
    assign flush_pend = st_q.flush;
    assign irq_enable = st_q.irq_en;
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr,
    input logic [1:0]    cpu_addr,
    input logic          pop_req,
    input logic [23:0]   pop_data,
    input logic          half_irq,
    input logic [CW-1:0] occ_words,
    input logic [CW-1:0] cap_words,
    input logic          flag_over,
    input logic          flag_under,
    input logic          flush_pend,
    input logic          irq_enable
);
    assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ_words <= cap_words);

    assert_push_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr == 2'd2 && occ_words < cap_words && !flush_pend && !pop_req
        |=> occ_words == $past(occ_words) + CW'(1));

    assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && cpu_addr == 2'd2 && occ_words >= cap_words && !flush_pend
        |=> flag_over);

    assert_underrun_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && occ_words == '0 && !flush_pend
        |=> pop_data == 24'd0 && flag_under);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend && !(cpu_wr && cpu_addr == 2'd0)
        |=> occ_words == '0 && !flush_pend);

    assert_flush_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pend && !(cpu_wr && cpu_addr == 2'd1)
        |=> flag_over == $past(flag_over));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq |-> irq_enable);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .pop_req   (pop_req),
    .pop_data  (pop_data),
    .half_irq  (half_irq),
    .occ_words (occ_words),
    .cap_words (cap_words),
    .flag_over (flag_over),
    .flag_under(flag_under),
    .flush_pend(flush_pend),
    .irq_enable(irq_enable)
);

// File: tb/sim_audio_tx_fifo.sv
module sim_audio_tx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_CAP [8] = '{256, 128, 64, 64, 32, 32, 32, 32};
    localparam logic [31:0] IRQ_BIT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [2:0]  ch_minus1 = 3'd0;
    logic        pop_req = 1'b0;
    logic [23:0] pop_data;
    logic        half_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_tx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ch_minus1(ch_minus1),
        .pop_req(pop_req), .pop_data(pop_data), .half_irq(half_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic pop();
        @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic flush(input logic [31:0] extra);
        logic [31:0] c;
        wr(2'd0, 32'h1 | extra);
        rd(2'd0, c);
        check("R8 flush bit visible", c & 32'h1, 32'h1);
        @(negedge clk);
        rd(2'd0, c);
        check("R8 flush bit self-clears", c & 32'h1, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, r); check("R1 status after reset", r, 32'h0);
        rd(2'd0, r); check("R1 control after reset", r, 32'h0);
        check("R1 irq after reset", 32'(half_irq), 32'h0);

        // Table walk: capacity per channel count (R3, R4, R6, R7, R8, R9)
        for (int i = 0; i < 8; i++) begin
            int capw;
            ch_minus1 = 3'(i);
            capw = EXP_CAP[i] * (i + 1);
            wr(2'd0, IRQ_BIT);
            check("R9 irq when empty", 32'(half_irq), 32'h1);
            for (int k = 0; k < capw; k++) wr(2'd2, 32'(k + 1));
            rd(2'd1, r);
            check("R3 level at capacity", r, 32'(EXP_CAP[i]) << 8);
            check("R9 irq low when full", 32'(half_irq), 32'h0);
            wr(2'd2, 32'h00AA_AAAA);
            rd(2'd1, r);
            check("R4 overrun sets flag, level kept", r, (32'(EXP_CAP[i]) << 8) | 32'h10);
            flush(IRQ_BIT);
            rd(2'd1, r);
            check("R8 flush empties, keeps flag", r, 32'h10);
            wr(2'd1, 32'h0);
            rd(2'd1, r);
            check("R7 status write zero clears", r, 32'h0);
        end

        // R2 ordering and 24-bit field
        ch_minus1 = 3'd0;
        wr(2'd2, 32'hFF12_3456);
        wr(2'd2, 32'h0000_ABCD);
        wr(2'd2, 32'h00FE_DC00);
        pop(); check("R2 first sample, upper bits ignored", 32'(pop_data), 32'h12_3456);
        pop(); check("R2 second sample", 32'(pop_data), 32'h00_ABCD);
        pop(); check("R2 third sample", 32'(pop_data), 32'hFE_DC00);

        // R5 underrun
        pop(); check("R5 underrun returns zero", 32'(pop_data), 32'h0);
        rd(2'd1, r); check("R5 underrun flag", r, 32'h1);

        // R7 selective clear: create overrun too, then keep only overrun
        for (int k = 0; k < 256; k++) wr(2'd2, 32'(k));
        wr(2'd2, 32'h5);
        rd(2'd1, r); check("R4 both flags set", r & 32'hFF, 32'h11);
        wr(2'd1, 32'h10);
        rd(2'd1, r); check("R7 keep overrun, clear underrun", r & 32'hFF, 32'h10);
        flush(32'h0);
        wr(2'd1, 32'h0);

        // R6 floor division with 3 channels
        ch_minus1 = 3'd2;
        for (int k = 0; k < 5; k++) wr(2'd2, 32'(k));
        rd(2'd1, r); check("R6 five words three channels", r, 32'h100);
        wr(2'd2, 32'h9);
        rd(2'd1, r); check("R6 six words three channels", r, 32'h200);
        flush(32'h0);

        // R9 threshold with 8 channels: capacity 32, half 16
        ch_minus1 = 3'd7;
        wr(2'd0, IRQ_BIT);
        for (int k = 0; k < 128; k++) wr(2'd2, 32'(k));
        check("R9 irq at exactly half", 32'(half_irq), 32'h1);
        for (int k = 0; k < 8; k++) wr(2'd2, 32'(k));
        check("R9 irq above half", 32'(half_irq), 32'h0);
        pop();
        check("R9 irq back at half level", 32'(half_irq), 32'h1);
        wr(2'd0, 32'h0);
        check("R9 irq disabled by control", 32'(half_irq), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule